// File: doc/BRIEF.md
# Packet Transmit Backpressure Adapter

This block sits between an application that produces framed packets and a link-layer transmit port. The application side is a plain ready/valid stream with zero ready latency, marked with start-of-packet and end-of-packet flags. The port side has no per-beat handshake. The port lowers its ready to pause traffic, but it still takes a bounded number of beats after that. Every beat shown with valid high in that window is consumed.

Each packet is held in an internal FIFO until its last beat has arrived. Only then does its first beat go out. Once a packet has started, its beats leave on consecutive cycles. Valid drops inside a packet only when the port has withdrawn ready. After ready falls, the adapter stops within a fixed number of beats. When ready returns and a packet was cut short, the rest of that packet goes out on the very next cycle.

Top module: `bpa_tx_adapter`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is low and in_ready is high.
- R2: The sop beat of a packet appears on the output only after the eop beat of that packet has been accepted at the input. A partly received packet produces no output beats.
- R3: Beats leave in the order they were accepted, with the data, sop and eop bits unchanged. No beat is lost or duplicated, and no beat is invented.
- R4: Between a packet's sop beat and its eop beat, out_valid is low in a cycle only if port_ready was low at the clock edge that started that cycle.
- R5: After a clock edge that samples port_ready low, at most SKID_BEATS further beats are presented (default 8, at most 15). Exactly that many are presented when that many buffered beats are available. After them, out_valid stays low until an edge samples port_ready high again. Valid is therefore low within 16 cycles of ready falling.
- R6: When a packet was suspended mid-way by backpressure, the first edge that samples port_ready high is followed directly by a cycle with out_valid high.
- R7: in_ready is high exactly when at least MAX_PKT FIFO entries are free. A beat offered while in_ready is low is not stored.
- R8: While port_ready stays high and another complete packet is stored, that packet's sop beat follows the previous eop beat in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source beat valid |
| in_data | input | DATA_W | Source beat payload |
| in_sop | input | 1 | Source beat is the first of a packet |
| in_eop | input | 1 | Source beat is the last of a packet |
| in_ready | output | 1 | Adapter can accept a source beat this cycle |
| port_ready | input | 1 | Transmit port willing to take beats |
| out_valid | output | 1 | Beat presented to the port (always consumed) |
| out_data | output | DATA_W | Beat payload towards the port |
| out_sop | output | 1 | Output beat is the first of a packet |
| out_eop | output | 1 | Output beat is the last of a packet |

## Verification
First, a packet is fed with a long pause before its last beat. The output must stay silent during the pause, which separates store-and-forward from cut-through. Second, ready is dropped in the middle of a long packet. The bench counts the beats that still leave, which shows whether the stop window is honoured exactly, and then checks the very next cycle after ready returns. Third, the FIFO is filled while the port is stopped, so the exact fill level at which in_ready falls can be seen. A marker beat held at the input must never appear on the output. Fourth, two short stored packets are released together, which shows whether packets join without a gap.

// File: rtl/bpa_pkg.sv
`timescale 1ns/1ps
package bpa_pkg;
  // framing bits stored beside each beat in the packet FIFO
  typedef struct packed {
    logic sop;
    logic eop;
  } bpa_mark_t;
endpackage

// File: rtl/bpa_pkt_fifo.sv
`timescale 1ns/1ps
// Beat FIFO with first-word fall-through head. DEPTH must be a power of two.
module bpa_pkt_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + AW'(1);
    if (rd_en) rd_ptr_d = rd_ptr_q + AW'(1);
    cnt_d = cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];
  assign count   = cnt_q;

  // input gating must keep the array from being overrun
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < FULL_C));
  // the transmit side may only pull beats that exist
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q != '0));
endmodule

// File: rtl/bpa_tx_ctrl.sv
`timescale 1ns/1ps
// Transmit sequencer: packet gating, stop window and output beat register.
module bpa_tx_ctrl #(
  parameter int DATA_W     = 32,
  parameter int SKID_BEATS = 8,
  parameter int PKT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_ready,
  input  logic              wr_eop,
  input  logic [DATA_W-1:0] head_data,
  input  logic              head_sop,
  input  logic              head_eop,
  output logic              pop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int WIN_W = $clog2(SKID_BEATS + 1);
  localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(SKID_BEATS);

  logic [WIN_W-1:0]  win_q, win_d;   // beats launched since ready fell
  logic [PKT_W-1:0]  pkt_q, pkt_d;   // complete packets held in the FIFO
  logic              mid_q, mid_d;   // a packet is open on the output
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              sop_q, eop_q;
  logic              allow, have;

  always_comb begin
    allow = port_ready || (win_q < WIN_MAX);
    have  = mid_q || (pkt_q != '0);
    pop   = allow && have;

    if (port_ready)          win_d = '0;
    else if (win_q == WIN_MAX) win_d = win_q;
    else                     win_d = win_q + WIN_W'(1);

    pkt_d = pkt_q + PKT_W'(wr_eop) - PKT_W'(pop && head_eop);
    mid_d = pop ? !head_eop : mid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= WIN_MAX;
      pkt_q <= '0;
      mid_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      win_q <= win_d;
      pkt_q <= pkt_d;
      mid_q <= mid_d;
      vld_q <= pop;
    end
  end

  // payload register, loaded only when a beat is launched
  always_ff @(posedge clk) begin
    if (pop) begin
      data_q <= head_data;
      sop_q  <= head_sop;
      eop_q  <= head_eop;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;

  // an open packet keeps flowing while the port is ready
  assert_no_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_q && port_ready) |=> vld_q);
  // once the window is used up nothing more leaves
  assert_stop_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_ready && (win_q == WIN_MAX)) |=> !vld_q);
  // a suspended packet resumes right after ready returns
  assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(port_ready) && mid_q) |=> vld_q);
endmodule

// File: rtl/bpa_tx_adapter.sv
`timescale 1ns/1ps
// Top: store-and-forward adapter from a ready/valid source to a port with
// a bounded stop window after ready falls.
// Constraints: DEPTH is a power of two, DEPTH >= 2*MAX_PKT, SKID_BEATS <= 15.
module bpa_tx_adapter
  import bpa_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAX_PKT    = 16,
  parameter int DEPTH      = 32,
  parameter int SKID_BEATS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  input  logic              port_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int FIFO_W = DATA_W + 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ROOM_C  = CNT_W'(MAX_PKT);

  logic              wr_en, pop;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [FIFO_W-1:0] head_word;
  bpa_mark_t         in_mark, head_mark;

  assign in_ready = (DEPTH_C - fifo_cnt) >= ROOM_C;
  assign wr_en    = in_valid && in_ready;
  assign in_mark  = '{sop: in_sop, eop: in_eop};
  assign head_mark = bpa_mark_t'(head_word[FIFO_W-1 -: 2]);

  bpa_pkt_fifo #(
    .WIDTH (FIFO_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data ({in_mark, in_data}),
    .rd_en   (pop),
    .rd_data (head_word),
    .count   (fifo_cnt)
  );

  bpa_tx_ctrl #(
    .DATA_W     (DATA_W),
    .SKID_BEATS (SKID_BEATS),
    .PKT_W      (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_ready (port_ready),
    .wr_eop     (wr_en && in_eop),
    .head_data  (head_word[DATA_W-1:0]),
    .head_sop   (head_mark.sop),
    .head_eop   (head_mark.eop),
    .pop        (pop),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_sop    (out_sop),
    .out_eop    (out_eop)
  );
endmodule

// File: tb/bpa_tx_adapter_test.sv
`timescale 1ns/1ps
module bpa_tx_adapter_test;
  localparam int DW   = 32;
  localparam int MAXP = 16;
  localparam int DEP  = 32;
  localparam int SKID = 8;

  logic          clk, rst_n;
  logic          in_valid, in_sop, in_eop, in_ready;
  logic [DW-1:0] in_data;
  logic          port_ready;
  logic          out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int eops_in = 0;
  int sops_out = 0;
  bit mon_mid = 0;
  bit pr_prev = 0;
  logic [DW+1:0] exp_q[$];
  logic [DW+1:0] exp_e;

  bpa_tx_adapter #(.DATA_W(DW), .MAX_PKT(MAXP), .DEPTH(DEP), .SKID_BEATS(SKID)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready), .port_ready(port_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // output monitor: order and content (R3), gating (R2), gaps (R4)
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected beat", out_data, 0);
        else begin
          exp_e = exp_q.pop_front();
          check({out_sop, out_eop, out_data} == exp_e, "R3 beat",
                {out_sop, out_eop, out_data}, exp_e);
        end
        if (out_sop) begin
          check(eops_in > sops_out, "R2 sop before eop accepted", sops_out, eops_in);
          sops_out++;
        end
        mon_mid = !out_eop;
      end else if (mon_mid && pr_prev) begin
        check(0, "R4 gap inside packet", 0, 1);
      end
    end
    pr_prev = port_ready;
  end

  task automatic drive_beat(input logic [DW-1:0] d, input bit s, input bit e);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
      #1;
      if (in_ready) begin
        exp_q.push_back({s, e, d});
        if (e) eops_in++;
        done = 1;
      end
    end
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send_pkt(input int len, input logic [DW-1:0] base);
    for (int i = 0; i < len; i++) drive_beat(base + DW'(i), i == 0, i == len - 1);
    idle_input();
  endtask

  task automatic drain();
    int w = 0;
    while (exp_q.size() != 0 && w < 500) begin
      @(negedge clk);
      w++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all beats delivered", exp_q.size(), 0);
  endtask

  // stop the port and let the stop window run out
  task automatic park();
    @(negedge clk);
    port_ready = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; port_ready = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  // partial packet must stay inside (R2), then flow intact (R3, R4)
  task automatic t_store_forward();
    @(negedge clk);
    port_ready = 1'b1;
    for (int i = 0; i < 5; i++) drive_beat(32'h100 + i, i == 0, 1'b0);
    idle_input();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #2;
      check(out_valid == 1'b0, "R2 no output from partial packet", out_valid, 0);
    end
    drive_beat(32'h105, 1'b0, 1'b1);
    idle_input();
    drain();
  endtask

  // stop window (R5) and one-cycle resume (R6)
  task automatic t_backpressure();
    int seen;
    int cnt;
    park();
    send_pkt(16, 32'h200);
    repeat (5) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R5 stored packet held while stopped", out_valid, 0);
    @(negedge clk);
    port_ready = 1'b1;
    seen = 0;
    while (seen < 3) begin
      @(negedge clk); #2;
      if (out_valid) seen++;
    end
    @(negedge clk);
    port_ready = 1'b0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #2;
      if (out_valid) cnt++;
    end
    check(cnt == SKID, "R5 beats after ready fell", cnt, SKID);
    check(out_valid == 1'b0, "R5 valid low after window", out_valid, 0);
    @(negedge clk);
    port_ready = 1'b1;
    @(negedge clk); #2;
    check(out_valid == 1'b1, "R6 resume one cycle after ready", out_valid, 1);
    drain();
  endtask

  // input gating at MAX_PKT free entries (R7)
  task automatic t_fill();
    park();
    send_pkt(16, 32'h300);
    #1;
    check(in_ready == 1'b1, "R7 ready with exactly MAX_PKT free", in_ready, 1);
    drive_beat(32'h400, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'hDEAD; in_sop = 1'b0; in_eop = 1'b0;
      #1;
      check(in_ready == 1'b0, "R7 ready low below MAX_PKT free", in_ready, 0);
    end
    port_ready = 1'b1;
    for (int i = 1; i < 10; i++) drive_beat(32'h400 + i, 1'b0, i == 9);
    idle_input();
    drain();
    #1;
    check(in_ready == 1'b1, "R7 ready back when empty", in_ready, 1);
  endtask

  // stored packets join without a gap (R8)
  task automatic t_back_to_back();
    int w = 0;
    park();
    send_pkt(4, 32'h500);
    send_pkt(5, 32'h600);
    @(negedge clk);
    port_ready = 1'b1;
    do begin
      @(negedge clk); #2;
      w++;
    end while (!(out_valid && out_eop) && w < 50);
    @(negedge clk); #2;
    check(out_valid && out_sop, "R8 next sop right after eop",
          {out_valid, out_sop}, 2'b11);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_store_forward();
    t_backpressure();
    t_fill();
    t_back_to_back();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule